// File: doc/BRIEF.md
# Status-Decoding Bus Command Controller

This block turns the 3-bit bus-cycle status code of a processor into the individual strobes that memory, I/O devices and an interrupt controller need. Between bus cycles the processor holds the status at the passive code 111. When the code moves to any other value except halt, the block latches the code. It then runs a short phase sequence that emits an address latch pulse, the command strobe that fits the cycle, and the data transceiver controls. All of these drop on the first clock edge after the status goes back to 111.

Two enable inputs gate the outputs. An active-low address enable gates every control and command output. An active-high command enable gates only the command strobes. A mode input decides what the dual-purpose output does. In I/O-bus mode it is an active-low peripheral transceiver enable. In system-bus mode it is an active-high cascade enable for an interrupt controller. The block does not model electrical tristate. An output-enable flag reports when the outputs would be driven.

Top module: `bus_cmd_ctrl`

## Requirements
- R1: The status code sets the cycle type: 000 interrupt acknowledge (`intack_n`), 001 I/O read (`io_rd_n`), 010 I/O write (`io_wr_n`, `io_awr_n`), 011 halt, 100 instruction fetch and 101 memory read (both `mem_rd_n`), 110 memory write (`mem_wr_n`, `mem_awr_n`), 111 passive. All strobes are active low.
- R2: `ale` is high for exactly one clock after the first rising edge at which the status has left 111 for a code other than 011. No address pulse is produced for halt.
- R3: Read, fetch, acknowledge and advanced-write strobes assert from the second clock of the cycle. They stay asserted until the first rising edge that samples status 111, and they are released after that edge.
- R4: The normal write strobes assert `ADV_LEAD` clocks after the matching advanced write strobes (default 1, so from the third clock). A normal write strobe is never active while its advanced strobe is inactive.
- R5: Halt (011) and passive (111) cycles assert no command strobe, no `ale` and no data enable.
- R6: While `addr_en_n` is high, every command strobe is inactive, `ale`, `dt_tx`, `data_en` and the cascade enable are low, `cas_pden` is high in I/O-bus mode, and `out_en` is low.
- R7: While `cmd_en` is low, all command strobes are inactive. `ale`, `dt_tx`, `data_en` and `cas_pden` still behave as in R2, R8, R9 and R10.
- R8: `dt_tx` is high (transmit) for the whole of a write cycle. It is low (receive) for read, fetch, acknowledge and idle.
- R9: `data_en` is high from the second clock of any active cycle until the cycle ends.
- R10: With `io_bus_mode` high, `cas_pden` is the inverse of `data_en`. With it low, `cas_pden` is high only during the `ale` clock of an interrupt acknowledge cycle.
- R11: After reset, all strobes are inactive, `ale`, `dt_tx` and `data_en` are low, and the state is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| status | input | 3 | Bus-cycle status code |
| addr_en_n | input | 1 | Active-low output enable for all controls and commands |
| cmd_en | input | 1 | Active-high enable for command strobes |
| io_bus_mode | input | 1 | 1 selects I/O-bus mode, 0 selects system-bus mode |
| ale | output | 1 | Address latch strobe |
| dt_tx | output | 1 | Transceiver direction, 1 means transmit |
| data_en | output | 1 | Transceiver enable |
| cas_pden | output | 1 | Peripheral enable (low active) or cascade enable (high active), chosen by mode |
| intack_n | output | 1 | Interrupt acknowledge strobe |
| io_rd_n | output | 1 | I/O read strobe |
| io_wr_n | output | 1 | I/O write strobe |
| io_awr_n | output | 1 | Advanced I/O write strobe |
| mem_rd_n | output | 1 | Memory read strobe |
| mem_wr_n | output | 1 | Memory write strobe |
| mem_awr_n | output | 1 | Advanced memory write strobe |
| out_en | output | 1 | High while the outputs are driven |

## Verification
The assertions assume that the status input returns to 111 between any two bus cycles. They also assume it never jumps straight from one active code to another, because the one-strobe and release properties depend on that. The stimulus always frames each code with at least two passive clocks. It changes status, enables and mode only on falling edges, and it holds the enables and mode constant for a whole sweep of the eight codes.

// File: rtl/bcc_pkg.sv
package bcc_pkg;

   typedef enum logic [2:0] {
      ST_INTA  = 3'b000,
      ST_IORD  = 3'b001,
      ST_IOWR  = 3'b010,
      ST_HALT  = 3'b011,
      ST_FETCH = 3'b100,
      ST_MRD   = 3'b101,
      ST_MWR   = 3'b110,
      ST_IDLE  = 3'b111
   } bus_st_e;

   // active-high internal command set
   typedef struct packed {
      logic ack;
      logic iord;
      logic iowr;
      logic iowr_adv;
      logic mrd;
      logic mwr;
      logic mwr_adv;
   } cmd_t;

endpackage

// File: rtl/bcc_seq.sv
module bcc_seq
   import bcc_pkg::*;
#(
   parameter int ADV_LEAD = 1
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic [2:0] status,
   output logic       ale_q,
   output logic       active,
   output bus_st_e    kind,
   output logic       first_ph,
   output logic       cmd_on,
   output logic       late_on
);

   localparam int PH_MAX = ADV_LEAD + 1;
   localparam int PW     = $clog2(PH_MAX + 1);

   generate
      if (ADV_LEAD < 1) begin : g_bad_lead
         $error("bcc_seq: ADV_LEAD must be at least 1");
      end
   endgenerate

   bus_st_e       prev_st;
   logic [PW-1:0] phase;
   logic          start;

   assign start = (prev_st == ST_IDLE) &&
                  (bus_st_e'(status) != ST_IDLE) &&
                  (bus_st_e'(status) != ST_HALT);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         prev_st <= ST_IDLE;
         ale_q   <= 1'b0;
         active  <= 1'b0;
         kind    <= ST_IDLE;
         phase   <= '0;
      end else begin
         prev_st <= bus_st_e'(status);
         if (start) begin
            ale_q  <= 1'b1;
            active <= 1'b1;
            kind   <= bus_st_e'(status);
            phase  <= '0;
         end else begin
            ale_q <= 1'b0;
            if (bus_st_e'(status) == ST_IDLE) begin
               active <= 1'b0;
               kind   <= ST_IDLE;
               phase  <= '0;
            end else if (active && (phase != PW'(PH_MAX))) begin
               phase <= phase + 1'b1;
            end
         end
      end
   end

   assign first_ph = active && (phase == '0);
   assign cmd_on   = active && (phase >= PW'(1));
   assign late_on  = active && (phase >= PW'(PH_MAX));

endmodule

// File: rtl/bcc_decode.sv
module bcc_decode
   import bcc_pkg::*;
(
   input  bus_st_e kind,
   input  logic    active,
   input  logic    cmd_on,
   input  logic    late_on,
   output cmd_t    cmd,
   output logic    is_write,
   output logic    is_ack
);

   always_comb begin
      cmd      = '0;
      is_write = 1'b0;
      is_ack   = 1'b0;
      if (active) begin
         unique case (kind)
            ST_INTA:  begin cmd.ack  = cmd_on; is_ack = 1'b1; end
            ST_IORD:  cmd.iord = cmd_on;
            ST_IOWR:  begin
               cmd.iowr_adv = cmd_on;
               cmd.iowr     = late_on;
               is_write     = 1'b1;
            end
            ST_FETCH, ST_MRD: cmd.mrd = cmd_on;
            ST_MWR:   begin
               cmd.mwr_adv = cmd_on;
               cmd.mwr     = late_on;
               is_write    = 1'b1;
            end
            default: ;
         endcase
      end
   end

endmodule

// File: rtl/bcc_outgate.sv
module bcc_outgate
   import bcc_pkg::*;
#(
   parameter bit CMD_ACT_LOW = 1'b1
) (
   input  logic addr_en_n,
   input  logic cmd_en,
   input  logic io_bus_mode,
   input  cmd_t cmd,
   input  logic ale_q,
   input  logic first_ph,
   input  logic cmd_on,
   input  logic is_write,
   input  logic is_ack,
   output logic ale,
   output logic dt_tx,
   output logic data_en,
   output logic cas_pden,
   output cmd_t cmd_pins,
   output logic out_en
);

   logic ctl_ok;
   logic cmd_ok;
   cmd_t gated;

   assign ctl_ok  = ~addr_en_n;
   assign cmd_ok  = ctl_ok & cmd_en;
   assign gated   = cmd_ok ? cmd : '0;

   assign ale     = ctl_ok & ale_q;
   assign dt_tx   = ctl_ok & is_write;
   assign data_en = ctl_ok & cmd_on;
   assign out_en  = ctl_ok;

   assign cas_pden = io_bus_mode ? ~data_en
                                 : (ctl_ok & is_ack & first_ph);

   generate
      if (CMD_ACT_LOW) begin : g_low
         assign cmd_pins = ~gated;
      end else begin : g_high
         assign cmd_pins = gated;
      end
   endgenerate

endmodule

// File: rtl/bus_cmd_ctrl.sv
module bus_cmd_ctrl
   import bcc_pkg::*;
#(
   parameter int ADV_LEAD    = 1,
   parameter bit CMD_ACT_LOW = 1'b1
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic [2:0] status,
   input  logic       addr_en_n,
   input  logic       cmd_en,
   input  logic       io_bus_mode,
   output logic       ale,
   output logic       dt_tx,
   output logic       data_en,
   output logic       cas_pden,
   output logic       intack_n,
   output logic       io_rd_n,
   output logic       io_wr_n,
   output logic       io_awr_n,
   output logic       mem_rd_n,
   output logic       mem_wr_n,
   output logic       mem_awr_n,
   output logic       out_en
);

   logic    ale_q, active, first_ph, cmd_on, late_on, is_write, is_ack;
   bus_st_e kind;
   cmd_t    cmd, cmd_pins;

   bcc_seq #(.ADV_LEAD(ADV_LEAD)) u_seq (
      .clk      (clk),
      .rst_n    (rst_n),
      .status   (status),
      .ale_q    (ale_q),
      .active   (active),
      .kind     (kind),
      .first_ph (first_ph),
      .cmd_on   (cmd_on),
      .late_on  (late_on)
   );

   bcc_decode u_dec (
      .kind     (kind),
      .active   (active),
      .cmd_on   (cmd_on),
      .late_on  (late_on),
      .cmd      (cmd),
      .is_write (is_write),
      .is_ack   (is_ack)
   );

   bcc_outgate #(.CMD_ACT_LOW(CMD_ACT_LOW)) u_gate (
      .addr_en_n   (addr_en_n),
      .cmd_en      (cmd_en),
      .io_bus_mode (io_bus_mode),
      .cmd         (cmd),
      .ale_q       (ale_q),
      .first_ph    (first_ph),
      .cmd_on      (cmd_on),
      .is_write    (is_write),
      .is_ack      (is_ack),
      .ale         (ale),
      .dt_tx       (dt_tx),
      .data_en     (data_en),
      .cas_pden    (cas_pden),
      .cmd_pins    (cmd_pins),
      .out_en      (out_en)
   );

   assign intack_n  = cmd_pins.ack;
   assign io_rd_n   = cmd_pins.iord;
   assign io_wr_n   = cmd_pins.iowr;
   assign io_awr_n  = cmd_pins.iowr_adv;
   assign mem_rd_n  = cmd_pins.mrd;
   assign mem_wr_n  = cmd_pins.mwr;
   assign mem_awr_n = cmd_pins.mwr_adv;

endmodule

// File: rtl/bcc_chk.sv
module bcc_chk (
   input logic       clk,
   input logic       rst_n,
   input logic [2:0] status,
   input logic       addr_en_n,
   input logic       cmd_en,
   input logic       io_bus_mode,
   input logic       ale,
   input logic       dt_tx,
   input logic       data_en,
   input logic       cas_pden,
   input logic       intack_n,
   input logic       io_rd_n,
   input logic       io_wr_n,
   input logic       io_awr_n,
   input logic       mem_rd_n,
   input logic       mem_wr_n,
   input logic       mem_awr_n,
   input logic       out_en
);

   logic [4:0] lead_set;
   logic       all_idle;

   assign lead_set = ~{intack_n, io_rd_n, io_awr_n, mem_rd_n, mem_awr_n};
   assign all_idle = &{intack_n, io_rd_n, io_wr_n, io_awr_n,
                       mem_rd_n, mem_wr_n, mem_awr_n};

   assert_one_cmd_R1: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(lead_set) <= 1);

   assert_ale_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
      ale |=> !ale);

   assert_release_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (status == 3'b111) |=> all_idle && !data_en);

   assert_iowr_after_adv_R4: assert property (@(posedge clk) disable iff (!rst_n)
      !io_wr_n |-> !io_awr_n);

   assert_mwr_after_adv_R4: assert property (@(posedge clk) disable iff (!rst_n)
      !mem_wr_n |-> !mem_awr_n);

   assert_aen_gate_R6: assert property (@(posedge clk) disable iff (!rst_n)
      addr_en_n |-> all_idle && !ale && !data_en && !dt_tx && !out_en);

   assert_cen_gate_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !cmd_en |-> all_idle);

   assert_write_dir_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (!io_awr_n || !mem_awr_n) |-> dt_tx);

   assert_cascade_ale_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (!io_bus_mode && cas_pden) |-> ale);

endmodule

bind bus_cmd_ctrl bcc_chk u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .status      (status),
   .addr_en_n   (addr_en_n),
   .cmd_en      (cmd_en),
   .io_bus_mode (io_bus_mode),
   .ale         (ale),
   .dt_tx       (dt_tx),
   .data_en     (data_en),
   .cas_pden    (cas_pden),
   .intack_n    (intack_n),
   .io_rd_n     (io_rd_n),
   .io_wr_n     (io_wr_n),
   .io_awr_n    (io_awr_n),
   .mem_rd_n    (mem_rd_n),
   .mem_wr_n    (mem_wr_n),
   .mem_awr_n   (mem_awr_n),
   .out_en      (out_en)
);

// File: tb/bus_cmd_ctrl_bench.sv
module bus_cmd_ctrl_bench;

   localparam int LEAD = 1;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [2:0] status = 3'b111;
   logic       addr_en_n = 1'b0;
   logic       cmd_en = 1'b1;
   logic       io_bus_mode = 1'b0;
   logic ale, dt_tx, data_en, cas_pden, intack_n, io_rd_n, io_wr_n, io_awr_n;
   logic mem_rd_n, mem_wr_n, mem_awr_n, out_en;

   int checks = 0;
   int errors = 0;
   bit done   = 1'b0;

   always #2.5 clk = ~clk;

   bus_cmd_ctrl #(.ADV_LEAD(LEAD)) u_bus_cmd_ctrl (
      .clk(clk), .rst_n(rst_n), .status(status), .addr_en_n(addr_en_n),
      .cmd_en(cmd_en), .io_bus_mode(io_bus_mode), .ale(ale), .dt_tx(dt_tx),
      .data_en(data_en), .cas_pden(cas_pden), .intack_n(intack_n),
      .io_rd_n(io_rd_n), .io_wr_n(io_wr_n), .io_awr_n(io_awr_n),
      .mem_rd_n(mem_rd_n), .mem_wr_n(mem_wr_n), .mem_awr_n(mem_awr_n),
      .out_en(out_en)
   );

   task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %b expected %b (status %b aen_n %b cen %b iob %b)",
                  req, act, exp, status, addr_en_n, cmd_en, io_bus_mode);
      end
   endtask

   // n = rising edges seen with this code applied
   task automatic step(input logic [2:0] code, input int n);
      logic en, cok, act, rd, wr, cmdph, late, exp_den;
      logic [6:0] exp_cmd;
      string tag;
      status = code;
      @(negedge clk);
      en    = !addr_en_n;
      cok   = en && cmd_en;
      act   = (code != 3'b111) && (code != 3'b011);
      wr    = (code == 3'b010) || (code == 3'b110);
      rd    = act && !wr;
      cmdph = act && (n >= 2);
      late  = act && (n >= 2 + LEAD);
      // order: ack, iord, iowr, iowr_adv, mrd, mwr, mwr_adv (active high)
      exp_cmd = '0;
      if (cok) begin
         exp_cmd[6] = cmdph && (code == 3'b000);
         exp_cmd[5] = cmdph && (code == 3'b001);
         exp_cmd[4] = late  && (code == 3'b010);
         exp_cmd[3] = cmdph && (code == 3'b010);
         exp_cmd[2] = cmdph && (code == 3'b100 || code == 3'b101);
         exp_cmd[1] = late  && (code == 3'b110);
         exp_cmd[0] = cmdph && (code == 3'b110);
      end
      if (!en) tag = "R6";
      else if (!cmd_en) tag = "R7";
      else if (!act) tag = "R5";
      else if (wr) tag = "R4";
      else if (rd && n >= 2) tag = "R1";
      else tag = "R3";
      chk(tag, {1'b0, ~{intack_n, io_rd_n, io_wr_n, io_awr_n, mem_rd_n, mem_wr_n, mem_awr_n}},
          {1'b0, exp_cmd});
      chk("R2", {7'd0, ale}, {7'd0, en && act && n == 1});
      chk("R8", {7'd0, dt_tx}, {7'd0, en && act && wr});
      exp_den = en && cmdph;
      chk("R9", {7'd0, data_en}, {7'd0, exp_den});
      chk("R10", {7'd0, cas_pden},
          {7'd0, io_bus_mode ? !exp_den : (en && act && code == 3'b000 && n == 1)});
      chk("R6", {7'd0, out_en}, {7'd0, en});
   endtask

   initial begin
      #40;
      // R11: reset state
      chk("R11", {ale, dt_tx, data_en, intack_n, io_rd_n, io_wr_n, mem_rd_n, mem_wr_n},
          8'b000_11111);
      chk("R11", {6'd0, io_awr_n, mem_awr_n}, 8'b0000_0011);
      @(negedge clk);
      rst_n = 1'b1;
      for (int m = 0; m < 2; m++) begin
         for (int a = 0; a < 2; a++) begin
            for (int c = 0; c < 2; c++) begin
               io_bus_mode = m[0];
               addr_en_n   = a[0];
               cmd_en      = c[0];
               for (int s = 0; s < 8; s++) begin
                  step(3'b111, 1);
                  step(3'b111, 1);
                  for (int k = 1; k <= 5; k++) step(s[2:0], k);
               end
               step(3'b111, 1);
            end
         end
      end
      done = 1'b1;
   end

   initial begin
      for (int w = 0; w < 20000; w++) begin
         @(posedge clk);
         if (done) break;
      end
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog: actual hung expected completion");
      end
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule